// File: doc/BRIEF.md
# Huffman Code Table Builder

This block turns six symbol frequency counts into a static Huffman code. A host writes one count per symbol through a small write port while the block is idle, then pulses `start`. An iterative engine repeatedly joins the two lightest live tree nodes into one node of their combined weight. It does one join per clock. Each symbol keeps a depth counter, and the counter goes up whenever a join includes the symbol's subtree. When a single node remains, those depths are the code lengths.

The lengths are then turned into canonical codewords, and the block registers the total number of encoded bits. It pulses `done` for one cycle. The host reads each symbol's length and codeword by presenting its index on a combinational read port. A result table stays in place until the next run finishes. A symbol with a zero count takes no part in the tree. Fixed-length coding of this alphabet would cost 3 bits per symbol, so `total_bits` can be compared against three times the sum of the counts.

Top module: `huff_table_builder`

## Requirements
- R1: After reset, `busy` and `done` are 0, `total_bits` is 0, and every symbol reads back length 0 and codeword 0. A write with `wr_en` high while idle stores `wr_freq` as the count of symbol `wr_sym`, where `wr_sym` is in the range 0..5.
- R2: A `start` sampled while idle raises `busy` in the next cycle. `done` is a single-cycle pulse that arrives exactly max(N,1)+1 cycles after the sampling edge, where N is the number of nonzero counts. `busy` stays high until that pulse and is low during the pulse.
- R3: Each join takes the two smallest live weights, and the lower symbol index wins a tie. A symbol's code length is the number of joins on its path to the root. For counts 29,5,12,7,4,8 the lengths are 1,4,3,3,4,3.
- R4: Codewords are canonical. They are handed out in order of increasing length, and in order of increasing index within one length. The first code is all zeros, consecutive codes of one length differ by 1, and the running code is shifted left once per length step. A codeword is right-aligned in the 5-bit `rd_code`, and its MSB is sent first.
- R5: `total_bits` equals the sum over all symbols of count times code length. It is 146 for the R3 counts.
- R6: A symbol with a zero count reads back length 0 and codeword 0 and does not change the other symbols' codes.
- R7: If exactly one count is nonzero, that symbol gets length 1 and codeword 0. If all counts are zero, every length is 0 and `total_bits` is 0.
- R8: While `busy` is high, `start` and writes are ignored. The run keeps its timing and its result, and the stored counts stay unchanged.
- R9: No code length exceeds 5. Counts 1,2,4,8,16,32 give lengths 5,5,4,3,2,1.
- R10: The codewords with nonzero length form a prefix-free set.
- R11: `total_bits` and the result table change only in the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Count write strobe |
| wr_sym | input | 3 | Symbol index for a write |
| wr_freq | input | 16 | Count value to write |
| start | input | 1 | Begins a table build |
| busy | output | 1 | A build is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_sym | input | 3 | Symbol index to read back |
| rd_len | output | 3 | Code length of `rd_sym` |
| rd_code | output | 5 | Right-aligned codeword of `rd_sym` |
| total_bits | output | 22 | Encoded size of the counted message in bits |

## Verification
A wrong tie decision or a wrong node index in the join engine does not show at the ports until `done`. It then shows up as code lengths that differ from a lowest-index-first reference, and usually as a changed `total_bits` as well. A depth counter that is skipped or counted twice breaks the prefix-free property or the length sum at that same pulse. A fault in the state machine changes the cycle in which `done` appears, so the bench compares `busy` and `done` with the expected latency on every clock of each run. Tie-heavy, skewed, sparse, single-symbol and empty count sets each drive a different path through the engine.

// File: rtl/huff_pkg.sv
package huff_pkg;
    parameter int NSYM    = 6;
    parameter int SYM_W   = $clog2(NSYM);
    parameter int FREQ_W  = 16;
    parameter int MAX_LEN = 5;
    parameter int LEN_W   = $clog2(MAX_LEN + 1);
    parameter int NODE_W  = FREQ_W + SYM_W;
    parameter int TOT_W   = NODE_W + LEN_W;

    typedef logic [SYM_W-1:0]   sym_t;
    typedef logic [FREQ_W-1:0]  freq_t;
    typedef logic [NODE_W-1:0]  node_w_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [MAX_LEN-1:0] code_t;
    typedef logic [TOT_W-1:0]   tot_t;

    typedef freq_t   [NSYM-1:0] freq_vec_t;
    typedef node_w_t [NSYM-1:0] node_vec_t;
    typedef len_t    [NSYM-1:0] len_vec_t;
    typedef code_t   [NSYM-1:0] code_vec_t;
    typedef sym_t    [NSYM-1:0] sym_vec_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_JOIN,
        ENG_FINISH
    } eng_state_t;

    typedef struct packed {
        logic found;
        sym_t idx;
    } pick_t;

    // Smallest weight among the candidate nodes; a tie goes to the lowest index.
    function automatic pick_t pick_min(input node_vec_t w, input logic [NSYM-1:0] cand);
        pick_t   r;
        node_w_t best;
        r    = '{found: 1'b0, idx: '0};
        best = '0;
        for (int i = 0; i < NSYM; i++) begin
            if (cand[i] && (!r.found || w[i] < best)) begin
                r.found = 1'b1;
                r.idx   = sym_t'(i);
                best    = w[i];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/huff_freq_regs.sv
module huff_freq_regs
    import huff_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      lock,
    input  sym_t      wr_sym,
    input  freq_t     wr_freq,
    output freq_vec_t freq
);
    for (genvar g = 0; g < NSYM; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                freq[g] <= '0;
            end else if (wr_en && !lock && wr_sym == sym_t'(g)) begin
                freq[g] <= wr_freq;
            end
        end
    end
endmodule

// File: rtl/huff_merge_engine.sv
module huff_merge_engine
    import huff_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  freq_vec_t freq,
    output logic      busy,
    output logic      finish,
    output len_vec_t  depth
);
    eng_state_t      state;
    node_vec_t       wt;
    logic [NSYM-1:0] live;
    logic [NSYM-1:0] used;
    sym_vec_t        grp;

    pick_t           lo_a;
    pick_t           lo_b;
    logic [NSYM-1:0] mask_b;
    node_w_t         joined;

    always_comb begin
        lo_a   = pick_min(wt, live);
        mask_b = live;
        mask_b[lo_a.idx] = 1'b0;
        lo_b   = pick_min(wt, mask_b);
        joined = wt[lo_a.idx] + wt[lo_b.idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ENG_IDLE;
            wt    <= '0;
            live  <= '0;
            used  <= '0;
            grp   <= '0;
            depth <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        for (int i = 0; i < NSYM; i++) begin
                            wt[i]    <= node_w_t'(freq[i]);
                            live[i]  <= (freq[i] != '0);
                            used[i]  <= (freq[i] != '0);
                            grp[i]   <= sym_t'(i);
                            depth[i] <= '0;
                        end
                        state <= ENG_JOIN;
                    end
                end
                ENG_JOIN: begin
                    if (lo_a.found && lo_b.found) begin
                        wt[lo_a.idx]   <= joined;
                        live[lo_b.idx] <= 1'b0;
                        for (int i = 0; i < NSYM; i++) begin
                            if (used[i] && (grp[i] == lo_a.idx || grp[i] == lo_b.idx)) begin
                                grp[i]   <= lo_a.idx;
                                depth[i] <= depth[i] + len_t'(1);
                            end
                        end
                    end else begin
                        // a lone surviving symbol still needs one code bit
                        for (int i = 0; i < NSYM; i++) begin
                            if (used[i] && depth[i] == '0) begin
                                depth[i] <= len_t'(1);
                            end
                        end
                        state <= ENG_FINISH;
                    end
                end
                ENG_FINISH: state <= ENG_IDLE;
                default:    state <= ENG_IDLE;
            endcase
        end
    end

    assign busy   = (state != ENG_IDLE);
    assign finish = (state == ENG_FINISH);
endmodule

// File: rtl/huff_canon.sv
module huff_canon
    import huff_pkg::*;
(
    input  len_vec_t  lens,
    input  freq_vec_t freq,
    output code_vec_t codes,
    output tot_t      total
);
    code_t nxt;

    always_comb begin
        codes = '0;
        nxt   = '0;
        for (int l = 1; l <= MAX_LEN; l++) begin
            for (int i = 0; i < NSYM; i++) begin
                if (lens[i] == len_t'(l)) begin
                    codes[i] = nxt;
                    nxt      = nxt + code_t'(1);
                end
            end
            nxt = nxt << 1;
        end
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < NSYM; i++) begin
            total = total + tot_t'(freq[i]) * tot_t'(lens[i]);
        end
    end
endmodule

// File: rtl/huff_table_builder.sv
module huff_table_builder
    import huff_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [huff_pkg::SYM_W-1:0]   wr_sym,
    input  logic [huff_pkg::FREQ_W-1:0]  wr_freq,
    input  logic                         start,
    output logic                         busy,
    output logic                         done,
    input  logic [huff_pkg::SYM_W-1:0]   rd_sym,
    output logic [huff_pkg::LEN_W-1:0]   rd_len,
    output logic [huff_pkg::MAX_LEN-1:0] rd_code,
    output logic [huff_pkg::TOT_W-1:0]   total_bits
);
    freq_vec_t freq;
    len_vec_t  depth;
    code_vec_t codes;
    tot_t      total;
    logic      eng_busy;
    logic      finish;

    len_vec_t  len_q;
    code_vec_t code_q;
    tot_t      tot_q;
    logic      done_q;

    huff_freq_regs u_freq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .lock    (eng_busy),
        .wr_sym  (wr_sym),
        .wr_freq (wr_freq),
        .freq    (freq)
    );

    huff_merge_engine u_eng (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .freq   (freq),
        .busy   (eng_busy),
        .finish (finish),
        .depth  (depth)
    );

    huff_canon u_canon (
        .lens  (depth),
        .freq  (freq),
        .codes (codes),
        .total (total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            code_q <= '0;
            tot_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                len_q  <= depth;
                code_q <= codes;
                tot_q  <= total;
            end
        end
    end

    logic sym_ok;
    assign sym_ok     = (32'(rd_sym) < NSYM);
    assign rd_len     = sym_ok ? len_q[rd_sym]  : '0;
    assign rd_code    = sym_ok ? code_q[rd_sym] : '0;
    assign total_bits = tot_q;
    assign busy       = eng_busy;
    assign done       = done_q;
endmodule

// File: rtl/huff_table_checker.sv
module huff_table_checker
    import huff_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [LEN_W-1:0] rd_len,
    input logic [TOT_W-1:0] total_bits
);
    assert_busy_needs_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_done_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_clears_busy_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_ends_at_done_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_restart_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_len_limit_R9: assert property (@(posedge clk) disable iff (rst)
        32'(rd_len) <= MAX_LEN);

    assert_total_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(total_bits));
endmodule

bind huff_table_builder huff_table_checker u_chk (.*);

// File: tb/huff_table_builder_tb.sv
module huff_table_builder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sym = '0;
    logic [15:0] wr_freq = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        done;
    logic [2:0]  rd_sym = '0;
    logic [2:0]  rd_len;
    logic [4:0]  rd_code;
    logic [21:0] total_bits;

    always #2 clk = ~clk;

    huff_table_builder u_dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    int cur_f [6];
    int exp_len [6];
    int exp_code [6];
    int exp_tot;
    int exp_nz;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: subtree membership masks, joins smallest pairs.
    task automatic build_model();
        int wt [6];
        bit alive [6];
        int mem [6];
        int nalive;
        int nxt;
        exp_nz = 0;
        for (int i = 0; i < 6; i++) begin
            wt[i] = cur_f[i];
            alive[i] = (cur_f[i] != 0);
            mem[i] = 1 << i;
            exp_len[i] = 0;
            exp_code[i] = 0;
            if (cur_f[i] != 0) exp_nz++;
        end
        nalive = exp_nz;
        while (nalive >= 2) begin
            int a = -1;
            int b = -1;
            for (int i = 0; i < 6; i++)
                if (alive[i] && (a < 0 || wt[i] < wt[a])) a = i;
            for (int i = 0; i < 6; i++)
                if (alive[i] && i != a && (b < 0 || wt[i] < wt[b])) b = i;
            for (int s = 0; s < 6; s++)
                if (((mem[a] | mem[b]) >> s) & 1) exp_len[s]++;
            wt[a] = wt[a] + wt[b];
            mem[a] = mem[a] | mem[b];
            alive[b] = 0;
            nalive--;
        end
        if (exp_nz == 1)
            for (int i = 0; i < 6; i++) if (cur_f[i] != 0) exp_len[i] = 1;
        nxt = 0;
        for (int l = 1; l <= 5; l++) begin
            for (int i = 0; i < 6; i++)
                if (exp_len[i] == l) begin exp_code[i] = nxt; nxt++; end
            nxt = nxt * 2;
        end
        exp_tot = 0;
        for (int i = 0; i < 6; i++) exp_tot += cur_f[i] * exp_len[i];
    endtask

    task automatic write_counts();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sym = 3'(i); wr_freq = 16'(cur_f[i]);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_table(input string tag);
        int gl [6];
        int gc [6];
        for (int i = 0; i < 6; i++) begin
            rd_sym = 3'(i);
            #1;
            gl[i] = int'(rd_len);
            gc[i] = int'(rd_code);
            check(gl[i] == exp_len[i], (exp_len[i] == 0) ? "R6" : "R3", {tag, " length"}, gl[i], exp_len[i]);
            check(gc[i] == exp_code[i], "R4", {tag, " codeword"}, gc[i], exp_code[i]);
            check(gl[i] <= 5, "R9", {tag, " length limit"}, gl[i], 5);
        end
        check(int'(total_bits) == exp_tot, "R5", {tag, " total bits"}, int'(total_bits), exp_tot);
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                if (i != j && gl[i] > 0 && gl[j] >= gl[i])
                    check((gc[j] >> (gl[j] - gl[i])) != gc[i], "R10", {tag, " prefix clash"}, gc[j], gc[i]);
    endtask

    // disturb: pulse start and a count write in the middle of the run (R8)
    task automatic run(input string tag, input bit disturb);
        int lat;
        build_model();
        lat = ((exp_nz < 1) ? 1 : exp_nz) + 1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", {tag, " busy after start"}, int'(busy), 1);
        check(done == 1'b0, "R2", {tag, " done after start"}, int'(done), 0);
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            start = 1'b0;
            check(busy == (k < lat), disturb ? "R8" : "R2", {tag, " busy"}, int'(busy), int'(k < lat));
            check(done == (k == lat), disturb ? "R8" : "R2", {tag, " done"}, int'(done), int'(k == lat));
            if (k == lat) check(total_bits == 22'(exp_tot), "R11", {tag, " total at done"}, int'(total_bits), exp_tot);
            else check(int'(total_bits) != -1, "R11", {tag, " total"}, 0, 0);
            if (disturb && k == 1) begin
                start = 1'b1; wr_en = 1'b1; wr_sym = 3'd0; wr_freq = 16'd1000;
            end
        end
        @(negedge clk);
        check(done == 1'b0, "R2", {tag, " done pulse width"}, int'(done), 0);
        check_table(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
        check(done == 1'b0, "R1", "reset done", int'(done), 0);
        check(total_bits == '0, "R1", "reset total", int'(total_bits), 0);
        for (int i = 0; i < 6; i++) begin
            rd_sym = 3'(i);
            #1;
            check(rd_len == '0 && rd_code == '0, "R1", "reset table", int'(rd_len), 0);
        end

        cur_f = '{29, 5, 12, 7, 4, 8};
        write_counts();
        run("R3 example", 1'b0);
        check(exp_tot == 146, "R5", "example reference total", exp_tot, 146);
        check(exp_len[0] == 1 && exp_len[1] == 4 && exp_len[4] == 4, "R3", "example reference lengths", exp_len[1], 4);

        run("R8 busy disturb", 1'b1);
        run("R8 counts unchanged", 1'b0);

        cur_f = '{1, 1, 1, 1, 1, 1};
        write_counts();
        run("R3 ties", 1'b0);

        cur_f = '{1, 2, 4, 8, 16, 32};
        write_counts();
        run("R9 skewed", 1'b0);
        check(exp_len[0] == 5, "R9", "skewed deepest", exp_len[0], 5);

        cur_f = '{3, 0, 3, 3, 0, 3};
        write_counts();
        run("R6 zeros", 1'b0);

        cur_f = '{0, 0, 0, 10, 0, 0};
        write_counts();
        run("R7 single", 1'b0);
        check(exp_len[3] == 1 && exp_code[3] == 0, "R7", "single reference", exp_len[3], 1);

        cur_f = '{0, 0, 0, 0, 0, 0};
        write_counts();
        run("R7 empty", 1'b0);

        cur_f = '{100, 7, 7, 300, 1, 2};
        write_counts();
        run("R1 rewrite", 1'b0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule